// File: doc/BRIEF.md
# Dual-Rate Wake Timer

This block is a 16-bit wake-up timer clocked by a fast system clock and advanced by a one-cycle strobe per positive edge of a 32.768 kHz slow clock. It raises a single-cycle wake pulse when the count reaches a programmable event value, and then clears itself. A sleep request puts it into the asleep state. Once the sleep has lasted beyond a threshold, the timer stops updating on every slow cycle. It then updates only on a coarse 256 Hz tick and steps by 128 each time, so the elapsed slow time stays exact.

Software sees a separate visible copy of the count. This copy is frozen while asleep and stays frozen after an external wake until the next tick the timer actually applies. In coarse mode that tick can be up to 128 slow cycles away. Fine counting resumes only after that first coarse tick, and the value then read contains the slept time plus the wait. Event bytes pass through a shadow register that commits on a slow edge. A byte-wise read latches the high byte so a 16-bit read is coherent. A sleep request that lands on a slow edge is flagged.

Top module: `dual_rate_wake_timer`

## Requirements
- R1: Out of reset the count, the visible count, `asleep`, `coarseMode`, `wakeIrq` and `sleepHazard` are 0. While awake in fine mode, each `slowTick` pulse adds 1 to the count and to the visible count.
- R2: A `swReset` pulse loads both the count and the visible count with 4 and leaves coarse mode. Later ticks continue counting from 4.
- R3: In fine mode, a tick that would take the count to the event value instead clears the count and the visible count to 0. It gives a one-cycle `wakeIrq` pulse and leaves the asleep state. The next tick gives 1.
- R4: `evtWrLo` stores `evtData` as the event low byte (bits 7:0) in a shadow. `evtWrHi` stores the high byte (bits 15:8) and arms a commit. Both bytes reach the match logic together on the next `slowTick`, and the match for that tick still uses the old value. A low-byte write with no high-byte write has no effect on matching.
- R5: An `rdLo` pulse places visible bits 7:0 on `rdData` in the next cycle and latches visible bits 15:8. An `rdHi` pulse then places the latched byte on `rdData`, even if the count has moved in between.
- R6: While asleep the visible count does not change, and ticks still advance the count. After a wake in fine mode, the next tick makes the visible count equal the count at sleep entry plus every tick since.
- R7: A free-running 7-bit prescaler counts slow ticks, and every 128th tick is a coarse tick. If the timer has been asleep for at least 131 slow ticks, the next coarse tick sets `coarseMode`. From then on the count rises by 128 on coarse ticks only, and the other slow ticks leave it unchanged.
- R8: After a wake in coarse mode, slow ticks other than coarse ticks leave the visible count unchanged. The first coarse tick sets the visible count to the sleep-entry count plus all slow ticks elapsed, and it clears `coarseMode`.
- R9: In coarse mode a coarse tick matches when the event value lies in the step just taken, that is strictly above the old count and at most 128 above it. That match clears the count and gives the same clear, wake and `wakeIrq` behaviour as R3.
- R10: A `sleepReq` pulse while awake that falls in the same cycle as `slowTick` produces a one-cycle `sleepHazard` pulse in the following cycle. A sleep request off the edge produces none.
- R11: `sleepReq` while awake sets `asleep`, and `extWake` while asleep clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle strobe per positive slow-clock edge |
| sleepReq | input | 1 | Request to enter the asleep state |
| extWake | input | 1 | External wake request |
| swReset | input | 1 | Load the count with 4 |
| evtWrLo | input | 1 | Write event low byte into the shadow |
| evtWrHi | input | 1 | Write event high byte and arm the commit |
| evtData | input | 8 | Event byte data |
| rdLo | input | 1 | Read low byte of the visible count and latch the high byte |
| rdHi | input | 1 | Read the latched high byte |
| rdData | output | 8 | Read data, valid one cycle after a read strobe |
| wakeIrq | output | 1 | One-cycle pulse on an event match |
| asleep | output | 1 | Asleep state |
| coarseMode | output | 1 | Timer updates at the coarse rate |
| sleepHazard | output | 1 | Sleep request coincided with a slow edge |

## Verification
Every cycle, the assertions check these properties. The event value changes only on a slow edge. The visible count stays still whenever no update is applied. A match leaves the count at zero and the timer awake. Coarse mode is entered only from a sleep that has lasted long enough. An external wake always leaves sleep, and the hazard flag only follows a sleep request that hit an edge. Only the bench scenarios can show the exact counts after the long sleeps. They can also show how many fine ticks the stale window after a coarse wake lasts, which coarse step catches a given event value, and that a 16-bit read stays coherent across a tick.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef struct packed {
    logic applyTick;
    logic stepBig;
    logic updVis;
    logic slowTick;
    logic swReset;
  } wtStrobe_t;
endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int PRE_W        = 7,
  parameter int COARSE_AFTER = 131
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      slowTick,
  input  logic      sleepReq,
  input  logic      extWake,
  input  logic      swReset,
  input  logic      hit,
  output wtStrobe_t str,
  output logic      asleep,
  output logic      coarseMode,
  output logic      sleepHazard
);
  localparam int LEN_W = $clog2(COARSE_AFTER + 1);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(COARSE_AFTER);

  logic [PRE_W-1:0] preQ;
  logic [LEN_W-1:0] lenQ;
  logic asleepQ, coarseQ, hazQ;
  logic coarseEdge, lenFull;

  assign coarseEdge = slowTick && (preQ == PRE_MAX);
  assign lenFull    = (lenQ >= LEN_LIM);

  always_comb begin
    str.applyTick = slowTick && (!coarseQ || coarseEdge);
    str.stepBig   = coarseQ;
    str.updVis    = !asleepQ;
    str.slowTick  = slowTick;
    str.swReset   = swReset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ    <= '0;
      lenQ    <= '0;
      asleepQ <= 1'b0;
      coarseQ <= 1'b0;
      hazQ    <= 1'b0;
    end else begin
      if (slowTick) preQ <= preQ + 1'b1;
      hazQ <= sleepReq && slowTick && !asleepQ;
      if (!asleepQ) lenQ <= '0;
      else if (slowTick && !lenFull) lenQ <= lenQ + 1'b1;
      if (hit) begin
        asleepQ <= 1'b0;
        coarseQ <= 1'b0;
      end else begin
        if (!asleepQ && sleepReq) asleepQ <= 1'b1;
        else if (asleepQ && extWake) asleepQ <= 1'b0;
        if (swReset) coarseQ <= 1'b0;
        else if (coarseQ && !asleepQ && coarseEdge) coarseQ <= 1'b0;
        else if (!coarseQ && asleepQ && coarseEdge && lenFull) coarseQ <= 1'b1;
      end
    end
  end

  assign asleep      = asleepQ;
  assign coarseMode  = coarseQ;
  assign sleepHazard = hazQ;

  // R7
  coarse_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coarseQ) |-> ($past(asleepQ) && $past(lenFull)));
  // R10
  hazard_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    hazQ |-> $past(sleepReq && slowTick));
  // R11
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (asleepQ && extWake) |=> !asleepQ);
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 7,
  parameter int RST_LOAD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wtStrobe_t         str,
  input  logic              evtWrLo,
  input  logic              evtWrHi,
  input  logic [BYTE_W-1:0] evtData,
  input  logic              rdLo,
  input  logic              rdHi,
  output logic [BYTE_W-1:0] rdData,
  output logic              hit,
  output logic              wakeIrq
);
  localparam int COUNT_W = 2 * BYTE_W;
  localparam logic [COUNT_W-1:0] STEP_C = COUNT_W'(1) << PRE_W;
  localparam logic [COUNT_W-1:0] LOAD_C = COUNT_W'(RST_LOAD);

  logic [COUNT_W-1:0] cntQ, visQ, evtQ, cntNxt, gap;
  logic [BYTE_W-1:0]  shLo, shHi, hiLatch;
  logic               pendQ, wakeQ;

  assign cntNxt = cntQ + (str.stepBig ? STEP_C : COUNT_W'(1));
  assign gap    = evtQ - cntQ - COUNT_W'(1);
  assign hit    = str.applyTick && !str.swReset &&
                  (str.stepBig ? (gap < STEP_C) : (gap == '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      visQ  <= '0;
      wakeQ <= 1'b0;
    end else begin
      wakeQ <= hit;
      if (str.swReset) begin
        cntQ <= LOAD_C;
        visQ <= LOAD_C;
      end else if (hit) begin
        cntQ <= '0;
        visQ <= '0;
      end else if (str.applyTick) begin
        cntQ <= cntNxt;
        if (str.updVis) visQ <= cntNxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ  <= '1;
      shLo  <= '0;
      shHi  <= '0;
      pendQ <= 1'b0;
    end else begin
      if (str.slowTick && pendQ) begin
        evtQ  <= {shHi, shLo};
        pendQ <= 1'b0;
      end
      if (evtWrLo) shLo <= evtData;
      if (evtWrHi) begin
        shHi  <= evtData;
        pendQ <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      hiLatch <= '0;
    end else if (rdLo) begin
      rdData  <= visQ[BYTE_W-1:0];
      hiLatch <= visQ[COUNT_W-1:BYTE_W];
    end else if (rdHi) begin
      rdData  <= hiLatch;
    end
  end

  assign wakeIrq = wakeQ;

  // R3
  match_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeQ |-> (cntQ == '0 && visQ == '0));
  // R4
  evt_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(evtQ) |-> $past(str.slowTick));
  // R6
  vis_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.updVis && !hit && !str.swReset) |=> $stable(visQ));
  // R1
  fine_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.applyTick && !str.stepBig && !hit && !str.swReset) |=> (cntQ == $past(cntQ) + 1'b1));
endmodule

// File: rtl/dual_rate_wake_timer.sv
module dual_rate_wake_timer
  import wt_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int PRE_W        = 7,
  parameter int COARSE_AFTER = 131,
  parameter int RST_LOAD     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              sleepReq,
  input  logic              extWake,
  input  logic              swReset,
  input  logic              evtWrLo,
  input  logic              evtWrHi,
  input  logic [BYTE_W-1:0] evtData,
  input  logic              rdLo,
  input  logic              rdHi,
  output logic [BYTE_W-1:0] rdData,
  output logic              wakeIrq,
  output logic              asleep,
  output logic              coarseMode,
  output logic              sleepHazard
);
  wtStrobe_t str;
  logic      hit;

  wt_ctrl #(.PRE_W(PRE_W), .COARSE_AFTER(COARSE_AFTER)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .sleepReq(sleepReq),
    .extWake(extWake), .swReset(swReset), .hit(hit), .str(str),
    .asleep(asleep), .coarseMode(coarseMode), .sleepHazard(sleepHazard)
  );

  wt_datapath #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .RST_LOAD(RST_LOAD)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .evtWrLo(evtWrLo), .evtWrHi(evtWrHi),
    .evtData(evtData), .rdLo(rdLo), .rdHi(rdHi), .rdData(rdData),
    .hit(hit), .wakeIrq(wakeIrq)
  );

  // R3
  wake_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (!asleep && !coarseMode));
endmodule

// File: tb/dual_rate_wake_timer_bench.sv
module dual_rate_wake_timer_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic slowTick = 0, sleepReq = 0, extWake = 0, swReset = 0;
  logic evtWrLo = 0, evtWrHi = 0, rdLo = 0, rdHi = 0;
  logic [7:0] evtData = '0;
  logic [7:0] rdData;
  logic wakeIrq, asleep, coarseMode, sleepHazard;

  int nTests = 0, nFail = 0, irqSeen = 0;
  bit done = 0;

  // bench model state
  logic [15:0] mCnt = 0, mVis = 0, mEvt = 16'hFFFF;
  logic [7:0]  mShLo = 0, mShHi = 0;
  bit mPend = 0, mAsleep = 0, mCoarse = 0;
  int mPre = 0, mLen = 0, mIrq = 0;
  localparam int THR = 131;

  dual_rate_wake_timer u_dual_rate_wake_timer (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .sleepReq(sleepReq),
    .extWake(extWake), .swReset(swReset), .evtWrLo(evtWrLo), .evtWrHi(evtWrHi),
    .evtData(evtData), .rdLo(rdLo), .rdHi(rdHi), .rdData(rdData),
    .wakeIrq(wakeIrq), .asleep(asleep), .coarseMode(coarseMode),
    .sleepHazard(sleepHazard)
  );

  always #4 clk = ~clk;
  always @(negedge clk) if (wakeIrq) irqSeen++;

  task automatic chk(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mTick();
    bit edgeC, apply, hitM;
    logic [15:0] gap;
    edgeC = (mPre == 127);
    apply = !mCoarse || edgeC;
    gap   = mEvt - mCnt - 16'd1;
    hitM  = apply && (mCoarse ? (gap < 16'd128) : (gap == 16'd0));
    if (mAsleep && mLen < THR) mLen++;
    if (hitM) begin
      mCnt = 0; mVis = 0; mIrq++; mAsleep = 0; mCoarse = 0;
    end else begin
      if (apply) begin
        mCnt = mCnt + (mCoarse ? 16'd128 : 16'd1);
        if (!mAsleep) mVis = mCnt;
      end
      if (mCoarse && !mAsleep && edgeC) mCoarse = 0;
      else if (!mCoarse && mAsleep && edgeC && mLen >= THR) mCoarse = 1;
    end
    if (mPend) begin mEvt = {mShHi, mShLo}; mPend = 0; end
    mPre = (mPre + 1) % 128;
  endtask

  task automatic tick();
    @(negedge clk); slowTick = 1; mTick();
    @(negedge clk); slowTick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic goSleep();
    @(negedge clk); sleepReq = 1;
    if (!mAsleep) begin mAsleep = 1; mLen = 0; end
    @(negedge clk); sleepReq = 0;
  endtask

  task automatic goWake();
    @(negedge clk); extWake = 1; mAsleep = 0;
    @(negedge clk); extWake = 0;
  endtask

  task automatic doSwReset();
    @(negedge clk); swReset = 1; mCnt = 4; mVis = 4; mCoarse = 0;
    @(negedge clk); swReset = 0;
  endtask

  task automatic wrLo(logic [7:0] b);
    @(negedge clk); evtWrLo = 1; evtData = b; mShLo = b;
    @(negedge clk); evtWrLo = 0;
  endtask

  task automatic wrHi(logic [7:0] b);
    @(negedge clk); evtWrHi = 1; evtData = b; mShHi = b; mPend = 1;
    @(negedge clk); evtWrHi = 0;
  endtask

  task automatic readCnt(output logic [15:0] v);
    @(negedge clk); rdLo = 1;
    @(negedge clk); rdLo = 0; v[7:0] = rdData; rdHi = 1;
    @(negedge clk); rdHi = 0; v[15:8] = rdData;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v, base;
    int k, irq0;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    readCnt(v); chk("R1 reset count", v, 0);
    chk("R1 reset asleep", asleep, 0);
    chk("R1 reset coarse", coarseMode, 0);
    chk("R1 reset irq", wakeIrq, 0);
    chk("R1 reset hazard", sleepHazard, 0);
    ticks(10); readCnt(v); chk("R1 fine count", v, 10);
    // R2
    doSwReset(); readCnt(v); chk("R2 load four", v, 4);
    tick(); readCnt(v); chk("R2 count from four", v, 5);
    // R3 fine match at 8
    wrLo(8'd8); wrHi(8'd0);
    irq0 = irqSeen;
    ticks(2); chk("R3 no early match", irqSeen, irq0);
    tick(); @(negedge clk);
    chk("R3 irq pulse", irqSeen, irq0 + 1);
    readCnt(v); chk("R3 cleared", v, 0);
    tick(); readCnt(v); chk("R3 next tick one", v, 1);
    // R4 low byte only must not retarget match
    wrLo(8'd3); irq0 = irqSeen;
    ticks(3); readCnt(v); chk("R4 lo-only ignored count", v, 4);
    chk("R4 lo-only ignored irq", irqSeen, irq0);
    wrHi(8'hFF); wrLo(8'hFF); tick(); tick();
    readCnt(v); chk("R4 model count", v, mVis);
    chk("R4 irq vs model", irqSeen, mIrq);
    // R5 coherent read across byte carry
    doSwReset(); ticks(251);
    @(negedge clk); rdLo = 1;
    @(negedge clk); rdLo = 0; chk("R5 low byte", rdData, 8'hFF);
    tick();
    @(negedge clk); rdHi = 1;
    @(negedge clk); rdHi = 0; chk("R5 latched high", rdData, 0);
    readCnt(v); chk("R5 full read", v, 256);
    // R6 short sleep
    goSleep(); chk("R11 asleep set", asleep, 1);
    ticks(20); readCnt(v); chk("R6 frozen asleep", v, 256);
    goWake(); chk("R11 asleep cleared", asleep, 0);
    readCnt(v); chk("R6 stale after wake", v, 256);
    tick(); readCnt(v); chk("R6 includes sleep", v, 277);
    // R7/R8 long sleep
    base = v;
    goSleep(); ticks(300);
    chk("R7 coarse entered", coarseMode, 1);
    goWake(); k = 0;
    tick(); k++;
    if (coarseMode) begin
      readCnt(v); chk("R8 stale in coarse", v, base);
    end
    while (coarseMode && k < 200) begin tick(); k++; end
    chk("R8 coarse left", coarseMode, 0);
    readCnt(v); chk("R8 total elapsed", v, base + 300 + k);
    chk("R8 vs model", v, mVis);
    tick(); readCnt(v); chk("R1 fine after coarse", v, base + 301 + k);
    // R9 coarse window match
    base = mCnt + 16'd500;
    wrLo(base[7:0]); wrHi(base[15:8]); tick();
    irq0 = irqSeen; goSleep(); k = 0;
    while (irqSeen == irq0 && k < 800) begin tick(); k++; @(negedge clk); end
    chk("R9 coarse match fired", irqSeen, irq0 + 1);
    chk("R9 woke", asleep, 0);
    chk("R9 ticks vs model", irqSeen, mIrq);
    readCnt(v); chk("R9 cleared", v, 0);
    // R10 hazard
    @(negedge clk); sleepReq = 1; slowTick = 1; mTick(); mAsleep = 1; mLen = 0;
    @(negedge clk); sleepReq = 0; slowTick = 0;
    chk("R10 hazard pulse", sleepHazard, 1);
    @(negedge clk); chk("R10 hazard single", sleepHazard, 0);
    goWake();
    goSleep(); @(negedge clk); chk("R10 no hazard off edge", sleepHazard, 0);
    goWake();
    // random mix
    for (int i = 0; i < 2500; i++) begin
      int op;
      op = $urandom % 100;
      if (op < 70) tick();
      else if (op < 78) goSleep();
      else if (op < 84) goWake();
      else if (op < 86) doSwReset();
      else if (op < 90) begin
        v = mCnt + 16'($urandom % 600);
        wrLo(v[7:0]); wrHi(v[15:8]);
      end else begin
        readCnt(v); chk("R6 random read", v, mVis);
        chk("R11 random asleep", asleep, mAsleep);
        chk("R7 random coarse", coarseMode, mCoarse);
        chk("R9 random irq count", irqSeen, mIrq);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule